// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave for a byte-wide non-volatile store that sits on an open-drain two-wire bus. A fast system clock oversamples the bus clock and data lines. The block finds start and stop conditions and shifts bits in on each rising bus-clock edge. It answers only to a device-select byte whose top nibble is a fixed prefix and whose next three bits equal its strap inputs. Up to eight copies can share one bus.

After the device-select byte, a write takes a two-byte memory address and then one or more data bytes. Each data byte goes into the array, and the byte pointer wraps within its 64-byte page. A stop after at least one data byte starts a timed internal write cycle. During that cycle the slave refuses its device-select byte, so a master can poll for completion. Reads come in three kinds:
- a current-address read, from the internal pointer;
- a random read, which is an address-only write followed by a repeated start;
- a sequential read, which continues for as long as the master acknowledges.

A write-protect input blocks every change to the array and leaves reads unaffected.

The array depth is set by the address-width parameter. A width of 15 gives the full 32 KiB; the default is kept smaller. Only the low address bits are kept from the two address bytes.

Top module: `twi_eeprom`

## Requirements
- R1: While reset is high and after it is released, `sda_oe` is 0 and the slave is idle until a start condition arrives.
- R2: A device-select byte is acknowledged only when bits [7:4] are 1010 and bits [3:1] equal `strap_i`, with bit 0 giving the direction (1 = read). Any other byte gets no acknowledge. Acknowledge means the slave drives SDA low (`sda_oe` = 1) during the ninth clock.
- R3: Incoming bits are taken on the SCL rising edge, MSB first. `sda_oe` changes only while SCL is low.
- R4: A write carries a high and then a low memory-address byte, both acknowledged, then data bytes. Each acknowledged data byte is stored at the current address.
- R5: During a write the address advances inside its 64-byte page. After the page's last byte it returns to the first byte of the same page.
- R6: A sequential read returns consecutive bytes for as long as the master acknowledges. After the highest array address it continues at address 0.
- R7: The internal pointer holds the last accessed address plus one. A current-address read returns the byte there.
- R8: A random read (an address-only write, a repeated start, then a read-mode device byte) returns the byte at the given address.
- R9: While `wp_i` is 1, the device-select and address bytes are still acknowledged, each data byte gets no acknowledge, and the array keeps its contents. Reads work at either level of `wp_i`.
- R10: A stop that ends a write with at least one stored byte starts a write cycle of `WRITE_CYCLES` clocks. During the cycle the device-select byte gets no acknowledge.
- R11: A stop that arrives after only the device-select byte or only the address bytes starts no write cycle.
- R12: When the master answers a read byte with no acknowledge, the slave releases SDA and returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad (resolved wired-AND) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Hard-wired device-select bits |
| wp_i | input | 1 | 1 blocks writes to the array |

## Verification
Storing the last byte of a page and wrapping the pointer back to the page start happen on the same edge. A three-byte write that starts two bytes before a page end provokes this. It is judged by reading back the page's first byte and by a current-address read after a two-byte write that ends exactly on the boundary. The write-protect level and the acceptance of a data byte are likewise decided on one edge. A protected write is judged by the missing data acknowledge, by an immediate poll acknowledge (no write cycle was started) and by the unchanged read-back.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  // Bit-level phase of the serial engine
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACKTX,
    PH_TX,
    PH_ACKRX
  } phase_t;

  // Meaning of the byte currently being received
  typedef enum logic [1:0] {
    BK_DEV,
    BK_AHI,
    BK_ALO,
    BK_DATA
  } kind_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_p;
  logic              sda_p;
  logic              scl_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_now   = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_now & ~scl_p;
  assign scl_fall  = ~scl_now & scl_p;
  assign start_det = scl_now & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_now & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twi_eeprom_ram.sv
module twi_eeprom_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/twi_eeprom_wtimer.sv
module twi_eeprom_wtimer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)             left <= '0;
    else if (go)         left <= CW'(CYCLES);
    else if (left != '0) left <= left - 1'b1;
  end

  assign busy = (left != '0);

endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
  import twi_eeprom_pkg::*;
#(
  parameter int         AW           = 11,
  parameter int         PW           = 6,
  parameter int         WRITE_CYCLES = 5000,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [3:0] DEV_PREFIX   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic          scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic          busy, wcyc_go;
  phase_t        phase;
  kind_t         kind;
  logic          rw, mack, wrote_any;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx_sh, hi_byte;
  logic [AW-1:0] cur_addr, page_next, addr_inc;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata, rd_data;
  logic          dev_hit;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s)
  );

  twi_eeprom_ram #(.AW(AW), .DW(8)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(cur_addr), .rdata(rd_data)
  );

  twi_eeprom_wtimer #(.CYCLES(WRITE_CYCLES)) u_wtimer (
    .clk(clk), .rst(rst), .go(wcyc_go), .busy(busy)
  );

  assign dev_hit   = (sh[7:4] == DEV_PREFIX) && (sh[3:1] == strap_i) && !busy;
  assign page_next = {cur_addr[AW-1:PW], PW'(cur_addr[PW-1:0] + 1'b1)};
  assign addr_inc  = AW'(cur_addr + 1'b1);

  always_ff @(posedge clk) begin
    mem_we  <= 1'b0;
    wcyc_go <= 1'b0;
    if (rst) begin
      phase     <= PH_IDLE;
      kind      <= BK_DEV;
      rw        <= 1'b0;
      mack      <= 1'b0;
      wrote_any <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      tx_sh     <= '0;
      hi_byte   <= '0;
      cur_addr  <= '0;
      sda_oe    <= 1'b0;
    end else if (start_det) begin
      phase     <= PH_RX;
      kind      <= BK_DEV;
      cnt       <= '0;
      sda_oe    <= 1'b0;
      wrote_any <= 1'b0;
    end else if (stop_det) begin
      phase     <= PH_IDLE;
      sda_oe    <= 1'b0;
      wcyc_go   <= wrote_any;
      wrote_any <= 1'b0;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise && cnt != BITS_PER_BYTE) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == BITS_PER_BYTE) begin
            cnt   <= '0;
            phase <= PH_ACKTX;
            case (kind)
              BK_DEV: begin
                if (dev_hit) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  kind   <= BK_AHI;
                end else begin
                  phase  <= PH_IDLE;
                end
              end
              BK_AHI: begin
                sda_oe  <= 1'b1;
                hi_byte <= sh;
                kind    <= BK_ALO;
              end
              BK_ALO: begin
                sda_oe   <= 1'b1;
                cur_addr <= AW'({hi_byte, sh});
                kind     <= BK_DATA;
              end
              default: begin
                if (!wp_i) begin
                  sda_oe    <= 1'b1;
                  mem_we    <= 1'b1;
                  mem_waddr <= cur_addr;
                  mem_wdata <= sh;
                  cur_addr  <= page_next;
                  wrote_any <= 1'b1;
                end
              end
            endcase
          end
        end
        PH_ACKTX: begin
          if (scl_fall) begin
            if (rw) begin
              tx_sh    <= rd_data;
              sda_oe   <= ~rd_data[7];
              cur_addr <= addr_inc;
              cnt      <= '0;
              phase    <= PH_TX;
            end else begin
              sda_oe <= 1'b0;
              phase  <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == BITS_PER_BYTE) begin
              sda_oe <= 1'b0;
              phase  <= PH_ACKRX;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
            end
          end
        end
        PH_ACKRX: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx_sh    <= rd_data;
              sda_oe   <= ~rd_data[7];
              cur_addr <= addr_inc;
              cnt      <= '0;
              phase    <= PH_TX;
            end else begin
              sda_oe <= 1'b0;
              phase  <= PH_IDLE;
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk
  import twi_eeprom_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          wp_i,
  input logic          sda_oe,
  input logic          busy,
  input phase_t        phase,
  input kind_t         kind,
  input logic [3:0]    cnt,
  input logic          scl_fall,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic [AW-1:0] cur_addr
);

  // R3
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R10
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && phase == PH_RX && kind == BK_DEV && scl_fall && cnt == 4'd8) |=> !sda_oe);

  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wp_i) |-> !mem_we);

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_waddr[AW-1:PW] == cur_addr[AW-1:PW]));

  // R6
  rd_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TX && $past(phase) != PH_TX) |-> (cur_addr == AW'($past(cur_addr) + 1'b1)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> !sda_oe);

endmodule

bind twi_eeprom twi_eeprom_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .wp_i(wp_i), .sda_oe(sda_oe),
  .busy(busy), .phase(phase), .kind(kind), .cnt(cnt), .scl_fall(scl_fall),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .cur_addr(cur_addr)
);

// File: tb/twi_eeprom_bench.sv
module twi_eeprom_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HB         = 8;
  localparam int AW         = 11;
  localparam int WCYC       = 1500;
  localparam int NVEC       = 6;
  localparam logic [18:0] VEC [NVEC] = '{
    {11'd5,    8'h11}, {11'd64,   8'h2C}, {11'd300,  8'h93},
    {11'd777,  8'h4E}, {11'd1024, 8'hF0}, {11'd1500, 8'h07}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       wp = 1'b0;
  logic       sda_oe;
  wire        sda_bus = sda_m & ~sda_oe;

  int  n_chk = 0;
  int  n_fail = 0;
  int  r3_bad = 0;
  bit  done = 1'b0;
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_eeprom #(.AW(AW), .WRITE_CYCLES(WCYC)) u_twi_eeprom (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(strap), .wp_i(wp)
  );

  // R3 monitor: the slave's drive may not move while SCL stays high
  always @(negedge clk) begin
    if (!rst && scl && prev_scl && sda_oe !== prev_oe) r3_bad++;
    prev_scl <= scl;
    prev_oe  <= sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] devb(input logic [2:0] s, input logic r);
    return {4'b1010, s, r};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wt(HB); scl = 1'b1; wt(HB); sda_m = 1'b0; wt(HB); scl = 1'b0; wt(HB);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HB); scl = 1'b1; wt(HB); sda_m = 1'b1; wt(HB);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(HB); scl = 1'b1; wt(HB); scl = 1'b0;
    end
    sda_m = 1'b1; wt(HB); scl = 1'b1; wt(HB/2); ackd = ~sda_bus; wt(HB/2); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(HB); scl = 1'b1; wt(HB/2); b[i] = sda_bus; wt(HB/2); scl = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; wt(HB); scl = 1'b1; wt(HB); scl = 1'b0; sda_m = 1'b1;
  endtask

  task automatic wait_ready(output int polls);
    logic a;
    polls = 0;
    do begin
      bus_start(); send_byte(devb(strap, 1'b0), a); bus_stop(); polls++;
    end while (!a && polls < 100);
  endtask

  task automatic set_addr(input logic [15:0] a, output logic ok);
    logic k1, k2, k3;
    bus_start();
    send_byte(devb(strap, 1'b0), k1);
    send_byte(a[15:8], k2);
    send_byte(a[7:0], k3);
    ok = k1 & k2 & k3;
  endtask

  task automatic write_data(input logic [15:0] a, input int n, input logic [23:0] d,
                            output int polls);
    logic ok, k;
    set_addr(a, ok);
    chk(ok, "R4 address bytes acknowledged", int'(ok), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[23-8*i -: 8], k);
      chk(k, "R4 data byte acknowledged", int'(k), 1);
    end
    bus_stop();
    wait_ready(polls);
  endtask

  task automatic read_seq(input logic [15:0] a, input int n, output logic [23:0] got);
    logic ok, k;
    logic [7:0] b;
    got = '0;
    set_addr(a, ok);
    bus_start();
    send_byte(devb(strap, 1'b1), k);
    chk(ok & k, "R8 random read setup acknowledged", int'(ok & k), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      got[23-8*i -: 8] = b;
    end
    bus_stop();
  endtask

  task automatic cur_read(output logic [7:0] b);
    logic k;
    bus_start();
    send_byte(devb(strap, 1'b1), k);
    chk(k, "R7 read-mode device byte acknowledged", int'(k), 1);
    recv_byte(1'b0, b);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic       a, ok;
    logic [7:0] b;
    logic [23:0] got;
    int         polls;

    // R1: reset state
    wt(6);
    chk(sda_oe == 1'b0, "R1 sda_oe low in reset", int'(sda_oe), 0);
    rst = 1'b0;
    wt(4);
    chk(sda_oe == 1'b0, "R1 sda_oe low after reset", int'(sda_oe), 0);

    // R2: device select matching
    bus_start(); send_byte(devb(3'b011, 1'b0), a); bus_stop();
    chk(!a, "R2 strap mismatch ignored", int'(a), 0);
    bus_start(); send_byte({4'b1011, strap, 1'b0}, a); bus_stop();
    chk(!a, "R2 prefix mismatch ignored", int'(a), 0);
    bus_start(); send_byte(devb(strap, 1'b0), a); bus_stop();
    chk(a, "R2 matching device acknowledged", int'(a), 1);

    // R4 R8 R10: vector table of byte writes and random read-back
    for (int i = 0; i < NVEC; i++) begin
      write_data({5'b0, VEC[i][18:8]}, 1, {VEC[i][7:0], 16'h0}, polls);
      chk(polls > 1, "R10 poll refused during write cycle", polls, 2);
      read_seq({5'b0, VEC[i][18:8]}, 1, got);
      chk(got[23:16] == VEC[i][7:0], "R8 random read data", int'(got[23:16]), int'(VEC[i][7:0]));
    end

    // R11: address-only access starts no write cycle
    set_addr(16'd300, ok);
    bus_stop();
    wait_ready(polls);
    chk(polls == 1, "R11 no write cycle after address-only stop", polls, 1);

    // R5 R7: page wrap during write
    write_data(16'd128, 1, 24'h5A0000, polls);
    write_data(16'd190, 2, 24'hA1A200, polls);
    cur_read(b);
    chk(b == 8'h5A, "R5 R7 pointer back at page start", int'(b), 'h5A);
    write_data(16'd190, 3, 24'hB1B2B3, polls);
    read_seq(16'd128, 1, got);
    chk(got[23:16] == 8'hB3, "R5 third byte wrapped to page start", int'(got[23:16]), 'hB3);
    read_seq(16'd190, 2, got);
    chk(got[23:16] == 8'hB1, "R6 sequential first byte", int'(got[23:16]), 'hB1);
    chk(got[15:8] == 8'hB2, "R6 sequential second byte", int'(got[15:8]), 'hB2);

    // R7: current-address read after a one-byte random read
    read_seq(16'd190, 1, got);
    cur_read(b);
    chk(b == 8'hB2, "R7 current address is last plus one", int'(b), 'hB2);

    // R6: sequential read wraps from top address to 0
    write_data(16'd2047, 1, 24'hC70000, polls);
    write_data(16'd0, 1, 24'h0C0000, polls);
    read_seq(16'd2047, 2, got);
    chk(got[23:16] == 8'hC7, "R6 top address byte", int'(got[23:16]), 'hC7);
    chk(got[15:8] == 8'h0C, "R6 wrap to address 0", int'(got[15:8]), 'h0C);

    // R9: write protect
    wp = 1'b1;
    set_addr(16'd128, ok);
    chk(ok, "R9 address bytes acknowledged under protect", int'(ok), 1);
    send_byte(8'hEE, a);
    chk(!a, "R9 data byte refused under protect", int'(a), 0);
    bus_stop();
    wait_ready(polls);
    chk(polls == 1, "R9 R11 no write cycle under protect", polls, 1);
    read_seq(16'd128, 1, got);
    chk(got[23:16] == 8'hB3, "R9 array unchanged and readable", int'(got[23:16]), 'hB3);
    wp = 1'b0;

    // R12: release after master NACK
    set_addr(16'd5, ok);
    bus_start();
    send_byte(devb(strap, 1'b1), a);
    recv_byte(1'b0, b);
    wt(HB/2);
    chk(sda_oe == 1'b0, "R12 SDA released after master NACK", int'(sda_oe), 0);
    chk(b == 8'h11, "R12 byte before NACK", int'(b), 'h11);
    bus_stop();

    // R3: drive never changed while SCL high
    chk(r3_bad == 0, "R3 drive changes only with SCL low", r3_bad, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule